// File: doc/BRIEF.md
# Address Region Decoder with RAM Write-Protect

This block sits between a 32-bit processor bus and the memories and peripherals behind it. For each access it looks at the address and decides which region the address falls in. The regions are main RAM, boot ROM, the scratchpad, the I/O page, the control page and unmapped space. It also works out the offset inside that region, folding mirror copies down onto one physical range. Every output except one is combinational from the current address and request, so the decode result is ready in the same cycle as the access.

Writes are qualified here. A write to ROM, to unmapped space or to the control page never reaches a memory. Main RAM can be put into a read-only mode by a 32-bit write of a magic value to one control address. While that mode is set, RAM writes are suppressed and every other region behaves as before. This mode bit is the only state in the block, and reset clears it.

Top module: `mem_region_dec`

## Requirements
- R1: `region_sel` is one-hot, with bit 0 RAM, bit 1 ROM, bit 2 scratchpad, bit 3 I/O, bit 4 control page and bit 5 unmapped. `unmapped` equals bit 5.
- R2: Addresses whose bits [31:23] are 0x000, 0x100 or 0x140 select RAM. This is the first 8 MiB of the segments at 0x00000000, 0x80000000 and 0xA0000000. The offset is addr[20:0], so RAM repeats every 2 MiB.
- R3: Addresses whose bits [31:19] match 0x1FC00000 or 0xBFC00000 select ROM, with offset addr[18:0]. A write to ROM never raises `wr_en`.
- R4: Page 0x1F800 (addr[31:12]) selects the scratchpad, with offset addr[11:0]. Reads and writes are both allowed.
- R5: Page 0x1F801 selects I/O, with offset addr[11:0]. Writes are allowed.
- R6: Every other page, outside the control page, is unmapped. For these, `unmapped` is 1, the offset is addr[11:0] into a dummy page, and `wr_en` stays 0.
- R7: A write with `wr_word`=1 to 0xFFFE0130 and data 0x800 or 0x804 sets read-only mode. The mode takes effect from the next clock edge.
- R8: The same kind of write with data 0x0 or 0x1E988 clears read-only mode.
- R9: These leave the mode unchanged: any other data value, any other address in page 0xFFFE0, and writes with `wr_word`=0. The control page selects bit 4, with offset addr[11:0], never raises `wr_en`, and is not flagged unmapped.
- R10: While read-only mode is set, RAM writes give `wr_en`=0. Scratchpad and I/O writes still give `wr_en`=1.
- R11: Reset clears read-only mode.
- R12: `wr_en` is 1 only in a cycle where `wr_req` is 1. Decode outputs follow the address within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Access address |
| wr_req | input | 1 | Access is a write |
| wr_word | input | 1 | Write is a full 32-bit word |
| wr_data | input | 32 | Write data (used by the control address only) |
| region_sel | output | 6 | One-hot region select |
| offset | output | 21 | Folded in-region offset |
| wr_en | output | 1 | Write strobe qualified by region and protection |
| unmapped | output | 1 | Address falls in unmapped space |

## Verification
The bench checks the edges of each region. The last word of a 2 MiB RAM mirror must fold back to offset 0x1FFFFC. The first address past the 8 MiB RAM window and the first address past the 512 KiB ROM must both decode as unmapped; a decoder that compared too few address bits would return RAM or ROM there. The read-only mode is tested against every clearing value and every setting value, and against near-miss writes: a neighbouring control address, an unknown value, and a byte-wide write. A design that matched data or address loosely would flip the mode on one of these, and RAM writes would then be wrongly blocked or allowed. Resetting with protection active, and scratchpad and I/O writes under protection, catch gating that is stuck or applied too widely.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int PAGE_AW = 12;
    localparam int RAM_AW  = 21;
    localparam int ROM_AW  = 19;
    localparam int WIN_AW  = 23;
    localparam int OFS_W   = RAM_AW;
    localparam int PAGE_W  = ADDR_W - PAGE_AW;
    localparam int N_RAM_SEG = 3;
    localparam int N_ROM_SEG = 2;
    localparam int N_REGION  = 6;

    typedef enum logic [2:0] {
        RG_RAM  = 3'd0,
        RG_ROM  = 3'd1,
        RG_SPAD = 3'd2,
        RG_IO   = 3'd3,
        RG_CTRL = 3'd4,
        RG_NONE = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        RO_KEEP = 2'd0,
        RO_SET  = 2'd1,
        RO_CLR  = 2'd2
    } ro_act_e;

    localparam logic [ADDR_W-1:0] RAM_BASE [N_RAM_SEG] =
        '{32'h0000_0000, 32'h8000_0000, 32'hA000_0000};
    localparam logic [ADDR_W-1:0] ROM_BASE [N_ROM_SEG] =
        '{32'h1FC0_0000, 32'hBFC0_0000};

    localparam logic [PAGE_W-1:0] SPAD_PAGE = 20'h1F800;
    localparam logic [PAGE_W-1:0] IO_PAGE   = 20'h1F801;
    localparam logic [PAGE_W-1:0] CTRL_PAGE = 20'hFFFE0;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFE_0130;

    localparam logic [DATA_W-1:0] RO_ON_A  = 32'h0000_0800;
    localparam logic [DATA_W-1:0] RO_ON_B  = 32'h0000_0804;
    localparam logic [DATA_W-1:0] RO_OFF_A = 32'h0000_0000;
    localparam logic [DATA_W-1:0] RO_OFF_B = 32'h0001_E988;

    function automatic ro_act_e ro_action(input logic [DATA_W-1:0] d);
        if (d == RO_ON_A || d == RO_ON_B)
            return RO_SET;
        else if (d == RO_OFF_A || d == RO_OFF_B)
            return RO_CLR;
        else
            return RO_KEEP;
    endfunction

    function automatic logic [N_REGION-1:0] region_onehot(input region_e r);
        logic [N_REGION-1:0] v;
        v = '0;
        v[r] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mr_page_classify.sv
module mr_page_classify
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    logic [N_RAM_SEG-1:0] ram_hit;
    logic [N_ROM_SEG-1:0] rom_hit;
    logic [PAGE_W-1:0]    page;

    assign page = addr[ADDR_W-1:PAGE_AW];

    for (genvar i = 0; i < N_RAM_SEG; i++) begin : g_ram
        assign ram_hit[i] = addr[ADDR_W-1:WIN_AW] == RAM_BASE[i][ADDR_W-1:WIN_AW];
    end

    for (genvar j = 0; j < N_ROM_SEG; j++) begin : g_rom
        assign rom_hit[j] = addr[ADDR_W-1:ROM_AW] == ROM_BASE[j][ADDR_W-1:ROM_AW];
    end

    always_comb begin
        if (|ram_hit)
            region = RG_RAM;
        else if (|rom_hit)
            region = RG_ROM;
        else if (page == SPAD_PAGE)
            region = RG_SPAD;
        else if (page == IO_PAGE)
            region = RG_IO;
        else if (page == CTRL_PAGE)
            region = RG_CTRL;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/mr_offset_fold.sv
module mr_offset_fold
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  region_e           region,
    output logic [OFS_W-1:0]  ofs
);
    always_comb begin
        ofs = '0;
        unique case (region)
            RG_RAM:  ofs = addr[RAM_AW-1:0];
            RG_ROM:  ofs = OFS_W'(addr[ROM_AW-1:0]);
            default: ofs = OFS_W'(addr[PAGE_AW-1:0]);
        endcase
    end
endmodule

// File: rtl/mr_protect.sv
module mr_protect
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  region_e           region,
    output logic              wr_en,
    output logic              ram_ro
);
    logic    ctrl_hit;
    ro_act_e act;

    assign ctrl_hit = wr_req && wr_word && (addr == CTRL_ADDR);
    assign act      = ro_action(wr_data);

    always_ff @(posedge clk) begin
        if (rst)
            ram_ro <= 1'b0;
        else if (ctrl_hit && act == RO_SET)
            ram_ro <= 1'b1;
        else if (ctrl_hit && act == RO_CLR)
            ram_ro <= 1'b0;
    end

    always_comb begin
        unique case (region)
            RG_RAM:        wr_en = wr_req && !ram_ro;
            RG_SPAD, RG_IO: wr_en = wr_req;
            default:       wr_en = 1'b0;
        endcase
    end

    // R7
    ro_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && (wr_data == RO_ON_A || wr_data == RO_ON_B)) |=> ram_ro);

    // R8
    ro_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && (wr_data == RO_OFF_A || wr_data == RO_OFF_B)) |=> !ram_ro);

    // R9
    ro_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && wr_word && addr == CTRL_ADDR) |=> $stable(ram_ro));

    // R10
    ro_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_ro && region == RG_RAM) |-> !wr_en);

    // R11
    ro_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ram_ro);
endmodule

// File: rtl/mem_region_dec.sv
module mem_region_dec
    import memmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_req,
    input  logic                wr_word,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [N_REGION-1:0] region_sel,
    output logic [OFS_W-1:0]    offset,
    output logic                wr_en,
    output logic                unmapped
);
    region_e region;
    logic    ram_ro;

    mr_page_classify u_cls (
        .addr   (addr),
        .region (region)
    );

    mr_offset_fold u_fold (
        .addr   (addr),
        .region (region),
        .ofs    (offset)
    );

    mr_protect u_prot (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_req  (wr_req),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .region  (region),
        .wr_en   (wr_en),
        .ram_ro  (ram_ro)
    );

    assign region_sel = region_onehot(region);
    assign unmapped   = region == RG_NONE;

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(region_sel));

    // R3
    rom_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        region_sel[RG_ROM] |-> !wr_en && offset[OFS_W-1:ROM_AW] == '0);

    // R6
    unm_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> !wr_en && offset[OFS_W-1:PAGE_AW] == '0);

    // R5
    io_page_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:PAGE_AW] == IO_PAGE) |-> region_sel[RG_IO]);

    // R12
    wr_qual_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_req);
endmodule

// File: tb/sim_mem_region_dec.sv
module sim_mem_region_dec;
    import memmap_pkg::*;

    typedef struct {
        logic [5:0]  sel;
        logic [20:0] ofs;
        logic        we;
        logic        unm;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        wr_req = 1'b0;
    logic        wr_word = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  region_sel;
    logic [20:0] offset;
    logic        wr_en;
    logic        unmapped;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    bit   ro_m = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    mem_region_dec u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_req(wr_req), .wr_word(wr_word),
        .wr_data(wr_data), .region_sel(region_sel), .offset(offset),
        .wr_en(wr_en), .unmapped(unmapped)
    );

    function automatic exp_t model(input logic [31:0] a, input logic w, input bit ro, input string tag);
        exp_t e;
        logic [8:0] win;
        win = a[31:23];
        e.tag = tag;
        e.ofs = {9'd0, a[11:0]};
        if (win == 9'h000 || win == 9'h100 || win == 9'h140) begin
            e.sel = 6'b000001; e.ofs = a[20:0]; e.we = w && !ro;
        end else if (a[31:19] == 13'h03F8 || a[31:19] == 13'h17F8) begin
            e.sel = 6'b000010; e.ofs = {2'd0, a[18:0]}; e.we = 1'b0;
        end else if (a[31:12] == 20'h1F800) begin
            e.sel = 6'b000100; e.we = w;
        end else if (a[31:12] == 20'h1F801) begin
            e.sel = 6'b001000; e.we = w;
        end else if (a[31:12] == 20'hFFFE0) begin
            e.sel = 6'b010000; e.we = 1'b0;
        end else begin
            e.sel = 6'b100000; e.we = 1'b0;
        end
        e.unm = e.sel[5];
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic w, input logic word,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        addr = a; wr_req = w; wr_word = word; wr_data = d;
        q.push_back(model(a, w, ro_m, tag));
        if (w && word && a == 32'hFFFE_0130) begin
            if (d == 32'h800 || d == 32'h804) ro_m = 1'b1;
            else if (d == 32'h0 || d == 32'h1E988) ro_m = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ro_m = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (region_sel !== e.sel || offset !== e.ofs || wr_en !== e.we || unmapped !== e.unm) begin
                    bad++;
                    $display("FAIL %s addr=%h: sel=%b ofs=%h we=%b unm=%b expected sel=%b ofs=%h we=%b unm=%b",
                             e.tag, addr, region_sel, offset, wr_en, unmapped, e.sel, e.ofs, e.we, e.unm);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired: done=0 expected done=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        // R11 reset state: RAM writable after reset
        drive(32'h0000_0000, 1'b1, 1'b1, 32'h1, "R11");
        // R2 RAM segments and mirrors
        drive(32'h8012_3456, 1'b0, 1'b1, 32'h0, "R2");
        drive(32'hA07F_FFFC, 1'b1, 1'b1, 32'h0, "R2");
        drive(32'h0060_0010, 1'b0, 1'b0, 32'h0, "R2");
        drive(32'h0080_0000, 1'b1, 1'b1, 32'h0, "R6");
        drive(32'h2000_0000, 1'b0, 1'b1, 32'h0, "R6");
        // R3 ROM
        drive(32'h1FC1_2345, 1'b0, 1'b1, 32'h0, "R3");
        drive(32'hBFC7_FFFF, 1'b1, 1'b1, 32'h0, "R3");
        drive(32'h1FC8_0000, 1'b1, 1'b1, 32'h0, "R6");
        // R4, R5, R6
        drive(32'h1F80_0ABC, 1'b1, 1'b1, 32'h0, "R4");
        drive(32'h1F80_1810, 1'b1, 1'b0, 32'h0, "R5");
        drive(32'h1F80_2000, 1'b1, 1'b1, 32'h0, "R6");
        // R12 read of RAM gives no strobe
        drive(32'h8000_0040, 1'b0, 1'b1, 32'h0, "R12");
        // R7 set read-only, R10 protection effects
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h800, "R7");
        drive(32'h8000_0004, 1'b1, 1'b1, 32'h0, "R7");
        drive(32'h1F80_0010, 1'b1, 1'b1, 32'h0, "R10");
        drive(32'h1F80_1040, 1'b1, 1'b1, 32'h0, "R10");
        drive(32'h0000_0100, 1'b0, 1'b1, 32'h0, "R10");
        // R8 clear with 0x1E988
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h1E988, "R8");
        drive(32'hA000_0008, 1'b1, 1'b1, 32'h0, "R8");
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h804, "R7");
        drive(32'h0000_0008, 1'b1, 1'b1, 32'h0, "R7");
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h0, "R8");
        drive(32'h0000_000C, 1'b1, 1'b1, 32'h0, "R8");
        // R9 near misses leave the mode set
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h800, "R9");
        drive(32'hFFFE_0130, 1'b1, 1'b1, 32'h12345, "R9");
        drive(32'hFFFE_0134, 1'b1, 1'b1, 32'h0, "R9");
        drive(32'hFFFE_0130, 1'b1, 1'b0, 32'h0, "R9");
        drive(32'hFFFE_0130, 1'b0, 1'b1, 32'h0, "R9");
        drive(32'h8010_0000, 1'b1, 1'b1, 32'h0, "R9");
        // R11 reset while protected
        do_reset();
        drive(32'h8010_0000, 1'b1, 1'b1, 32'h0, "R11");
        // R1 one-hot across regions
        drive(32'h1F80_1FFF, 1'b0, 1'b1, 32'h0, "R1");
        drive(32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0, "R1");
        @(negedge clk);
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule